// File: doc/BRIEF.md
# DMA Channel Control and Request Trigger

This block holds the 32-bit control register of one DMA channel and turns its request inputs into a single start signal for the transfer engine. A CPU-side write port loads the register, and the register value is always visible on a read port. Two 3-bit fields name the memory space that the channel reads from and the one it writes to. Each field is decoded into a one-hot space select and an internal/external flag.

Seven request inputs can start a transfer. Four come from internal peripherals and are qualified by the channel enable bit. Three come from external pins and are synchronized first. Each request is qualified by its own mask bit, and the qualified requests are merged into one signal. A rising edge of that signal sets a pending flag, which drives the start output. The transfer engine clears the flag with an acknowledge. A synchronous software reset clears the register and the pending flag.

Top module: `dma_chan_ctl`

## Requirements
- R1: After the asynchronous reset, the register reads 0x00000000, start_o is 0, and both select outputs show code 000.
- R2: Bit positions 6, 7, 15 through 22, 27 and 29 (mask 0x287F80C0) always read back as 0. Writes to these positions are discarded.
- R3: Bits 2:0 hold the destination space code and bits 5:3 hold the source space code. The matching select output is one-hot, with bit k set for code k. The codes are: 0 internal program, 1 internal X data, 2 internal Y data, 3 internal I/O, 4 external program, 5 external X data, 6 external Y data, 7 external I/O.
- R4: dst_ext_o and src_ext_o equal the top bit of their respective space code.
- R5: Mask bit 8+i enables request i. Requests 0 to 3 are int_req_i[3:0] and requests 4 to 6 are ext_req_i[2:0]. A request whose mask bit is clear has no effect on start_o.
- R6: Internal requests count only while the channel enable bit 31 is set. External requests do not depend on bit 31.
- R7: An external pin passes through two synchronizing flops. If a pin rises between edges, start_o goes high after the third rising clock edge.
- R8: start_o sets only on a rising edge of the merged request. A request that stays high does not set it again after an acknowledge.
- R9: ack_i clears start_o on the next edge. If an acknowledge and a new request edge arrive in the same cycle, start_o stays set.
- R10: sw_rst_i clears the whole register and start_o on the next edge. It takes priority over a write in the same cycle.
- R11: All bit positions that are not reserved read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_rst_i | input | 1 | Synchronous software reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| int_req_i | input | 4 | Internal peripheral request levels |
| ext_req_i | input | 3 | External request pins (asynchronous) |
| ack_i | input | 1 | Transfer engine acknowledge |
| start_o | output | 1 | Pending transfer start |
| dst_sel_o | output | 8 | One-hot destination space select |
| src_sel_o | output | 8 | One-hot source space select |
| dst_ext_o | output | 1 | Destination is external memory |
| src_ext_o | output | 1 | Source is external memory |

## Verification
The hardest case to reach is an acknowledge that lands in the same cycle as a fresh request edge. To reach it, a held request must first be dropped for one full cycle, so that the edge detector's stored sample falls back to low. The stimulus then raises the request and ack_i together and checks that start_o stays high, and on the next cycle checks that ack_i alone clears it. The external path is checked cycle by cycle, confirming that no edge shows up before the third clock.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_W    = 32;
  localparam int SPACE_W  = 3;
  localparam int N_SPACE  = 1 << SPACE_W;
  localparam int DST_LSB  = 0;
  localparam int SRC_LSB  = 3;
  localparam int N_INT    = 4;
  localparam int N_EXT    = 3;
  localparam int N_REQ    = N_INT + N_EXT;
  localparam int MASK_LSB = 8;
  localparam int EN_BIT   = 31;
  localparam logic [REG_W-1:0] RSVD_MASK = 32'h287F_80C0;

  typedef enum logic [SPACE_W-1:0] {
    SP_INT_PRG, SP_INT_XD, SP_INT_YD, SP_INT_IO,
    SP_EXT_PRG, SP_EXT_XD, SP_EXT_YD, SP_EXT_IO
  } space_e;
endpackage

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
  import dma_chan_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] RSVD = RSVD_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_rst_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] KEEP = ~RSVD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (sw_rst_i) q_o <= '0;
    else if (we_i)     q_o <= wdata_i & KEEP;
  end
endmodule

// File: rtl/dma_space_dec.sv
module dma_space_dec #(
  parameter int CODE_W = 3,
  localparam int N = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [N-1:0]      sel_o,
  output logic              ext_o
);
  for (genvar k = 0; k < N; k++) begin : g_sel
    assign sel_o[k] = (code_i == CODE_W'(k));
  end
  assign ext_o = code_i[CODE_W-1];
endmodule

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else begin
      ff_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) ff_q[s] <= ff_q[s-1];
    end
  end
  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/dma_req_trig.sv
module dma_req_trig #(
  parameter int N_INT = 4,
  parameter int N_EXT = 3,
  localparam int N = N_INT + N_EXT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_rst_i,
  input  logic [N_INT-1:0] int_req_i,
  input  logic [N_EXT-1:0] ext_req_i,
  input  logic             en_i,
  input  logic [N-1:0]     mask_i,
  input  logic             ack_i,
  output logic             req_any_o,
  output logic             pend_o
);
  logic [N-1:0] req_vec;
  logic         req_q, rise;

  assign req_vec   = {ext_req_i, int_req_i & {N_INT{en_i}}};
  assign req_any_o = |(req_vec & mask_i);
  assign rise      = req_any_o & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_o <= 1'b0;
    end else if (sw_rst_i) begin
      req_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      req_q <= req_any_o;
      if (rise)       pend_o <= 1'b1;  // new edge beats ack
      else if (ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_rst_i,
  input  logic               reg_we_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic [N_INT-1:0]   int_req_i,
  input  logic [N_EXT-1:0]   ext_req_i,
  input  logic               ack_i,
  output logic               start_o,
  output logic [N_SPACE-1:0] dst_sel_o,
  output logic [N_SPACE-1:0] src_sel_o,
  output logic               dst_ext_o,
  output logic               src_ext_o
);
  logic [REG_W-1:0] ctl_q;
  logic [N_EXT-1:0] ext_sync;
  logic             req_any;

  dma_ctl_reg #(.W(REG_W), .RSVD(RSVD_MASK)) i_reg (
    .clk_i, .rst_ni, .sw_rst_i,
    .we_i(reg_we_i), .wdata_i(reg_wdata_i), .q_o(ctl_q)
  );

  dma_space_dec #(.CODE_W(SPACE_W)) i_dst_dec (
    .code_i(ctl_q[DST_LSB +: SPACE_W]), .sel_o(dst_sel_o), .ext_o(dst_ext_o)
  );

  dma_space_dec #(.CODE_W(SPACE_W)) i_src_dec (
    .code_i(ctl_q[SRC_LSB +: SPACE_W]), .sel_o(src_sel_o), .ext_o(src_ext_o)
  );

  dma_req_sync #(.WIDTH(N_EXT), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(ext_req_i), .q_o(ext_sync)
  );

  dma_req_trig #(.N_INT(N_INT), .N_EXT(N_EXT)) i_trig (
    .clk_i, .rst_ni, .sw_rst_i,
    .int_req_i, .ext_req_i(ext_sync),
    .en_i(ctl_q[EN_BIT]), .mask_i(ctl_q[MASK_LSB +: N_REQ]),
    .ack_i, .req_any_o(req_any), .pend_o(start_o)
  );

  assign reg_rdata_o = ctl_q;
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk
  import dma_chan_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sw_rst_i,
  input logic               ack_i,
  input logic [REG_W-1:0]   reg_rdata_o,
  input logic [N_SPACE-1:0] dst_sel_o,
  input logic [N_SPACE-1:0] src_sel_o,
  input logic               dst_ext_o,
  input logic               src_ext_o,
  input logic               start_o,
  input logic               req_any_i
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & RSVD_MASK) == '0); // R2

  AST_DST_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(dst_sel_o) && dst_sel_o[reg_rdata_o[DST_LSB +: SPACE_W]]); // R3

  AST_SRC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(src_sel_o) && src_sel_o[reg_rdata_o[SRC_LSB +: SPACE_W]]); // R3

  AST_EXT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_ext_o == |dst_sel_o[N_SPACE-1:N_SPACE/2] &&
    src_ext_o == |src_sel_o[N_SPACE-1:N_SPACE/2]); // R4

  AST_SET_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(req_any_i)); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && ack_i && !req_any_i |=> !start_o); // R9

  AST_SW_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> reg_rdata_o == '0 && !start_o); // R10
endmodule

bind dma_chan_ctl dma_chan_ctl_chk i_chk (
  .clk_i, .rst_ni, .sw_rst_i, .ack_i, .reg_rdata_o,
  .dst_sel_o, .src_sel_o, .dst_ext_o, .src_ext_o, .start_o,
  .req_any_i(req_any)
);

// File: tb/test_dma_chan_ctl.sv
`timescale 1ns/1ps
module test_dma_chan_ctl;
  typedef struct {
    int          kind;  // 0 rdata 1 start 2 dst_sel 3 src_sel 4 dst_ext 5 src_ext
    logic [31:0] exp;
    string       rq;
  } item_t;

  localparam logic [31:0] WR_KEEP = 32'hD780_7F3F;

  logic        clk = 0, rst_ni = 0, sw_rst = 0, we = 0, ack = 0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  ireq = '0;
  logic [2:0]  ereq = '0;
  logic        start, dext, sext;
  logic [7:0]  dsel, ssel;
  int          checks = 0, errors = 0;
  bit          done = 0;
  item_t       q[$];
  item_t       it;
  logic [31:0] act;

  always #2 clk = ~clk;

  dma_chan_ctl i_dma_chan_ctl (
    .clk_i(clk), .rst_ni, .sw_rst_i(sw_rst), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .int_req_i(ireq), .ext_req_i(ereq), .ack_i(ack),
    .start_o(start), .dst_sel_o(dsel), .src_sel_o(ssel),
    .dst_ext_o(dext), .src_ext_o(sext)
  );

  function automatic logic [31:0] observe(int kind);
    case (kind)
      0: return rdata;
      1: return {31'b0, start};
      2: return {24'b0, dsel};
      3: return {24'b0, ssel};
      4: return {31'b0, dext};
      default: return {31'b0, sext};
    endcase
  endfunction

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0) begin
      it  = q.pop_front();
      act = observe(it.kind);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", it.rq, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_item(int kind, logic [31:0] exp, string rq);
    item_t e;
    e.kind = kind; e.exp = exp; e.rq = rq;
    q.push_back(e);
  endtask

  task automatic wr(logic [31:0] d);
    we = 1; wdata = d; step(); we = 0;
  endtask

  task automatic ack_pulse();
    ack = 1; step(); ack = 0;
  endtask

  initial begin
    step(2);
    rst_ni = 1;
    step();
    expect_item(0, 32'h0, "R1");
    expect_item(1, 0, "R1");
    expect_item(2, 8'h01, "R1");
    expect_item(3, 8'h01, "R1");

    wr(32'hFFFF_FFFF);
    expect_item(0, WR_KEEP, "R11");
    expect_item(2, 8'h80, "R3");
    expect_item(4, 1, "R4");
    wr(32'h287F_80C0);
    expect_item(0, 32'h0, "R2");

    for (int c = 0; c < 8; c++) begin
      wr({26'b0, 3'(7 - c), 3'(c)});
      expect_item(2, 32'(1) << c, "R3");
      expect_item(3, 32'(1) << (7 - c), "R3");
      expect_item(4, c / 4, "R4");
      expect_item(5, (7 - c) / 4, "R4");
    end

    // internal request, enabled and masked in
    wr(32'h8000_0100);
    expect_item(0, 32'h8000_0100, "R11");
    ireq = 4'b0001; step();
    expect_item(1, 1, "R5");
    ack_pulse();
    expect_item(1, 0, "R9");
    step(3);
    expect_item(1, 0, "R8");
    ireq = 0; step();

    // enable clear blocks internal request
    wr(32'h0000_0100);
    ireq = 4'b0001; step(2);
    expect_item(1, 0, "R6");
    ireq = 0; step();

    // unmasked request ignored, masked one accepted
    wr(32'h8000_0200);
    ireq = 4'b0001; step(2);
    expect_item(1, 0, "R5");
    ireq = 4'b0011; step();
    expect_item(1, 1, "R5");
    ireq = 0; ack_pulse();
    expect_item(1, 0, "R9");

    // external pin through synchronizer, enable off
    wr(32'h0000_1000);
    ereq = 3'b001; step();
    expect_item(1, 0, "R7");
    step();
    expect_item(1, 0, "R7");
    step();
    expect_item(1, 1, "R7");
    ereq = 0; ack_pulse();
    expect_item(1, 0, "R9");
    ereq = 3'b010; step(4);
    expect_item(1, 0, "R5");
    ereq = 0; step(3);

    // ack colliding with a new edge
    wr(32'h8000_0100);
    ireq = 4'b0001; step();
    expect_item(1, 1, "R8");
    ireq = 0; step();
    ireq = 4'b0001; ack = 1; step();
    expect_item(1, 1, "R9");
    step();
    expect_item(1, 0, "R9");
    ack = 0; ireq = 0; step();

    // software reset beats simultaneous write
    ireq = 4'b0001; step();
    expect_item(1, 1, "R10");
    sw_rst = 1; we = 1; wdata = 32'h8000_7F3F; step();
    sw_rst = 0; we = 0;
    expect_item(0, 32'h0, "R10");
    expect_item(1, 0, "R10");
    ireq = 0;
    step(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule